// File: doc/BRIEF.md
# Timer Compare Output Stage

This block keeps the single output-compare state bit of one timer channel and decides what a general-purpose pin shows. A counter elsewhere delivers a one-cycle match pulse and a one-cycle bottom pulse. Software can also raise a one-cycle force strobe. The block turns these events, together with a two-bit action field and the waveform mode, into set, clear or toggle actions on the state bit.

The same action field also takes over the pin. When either bit of the field is 1, the pin value comes from the state bit instead of from the port data bit. The pin direction always stays with the port direction bit. Software can therefore preload the state bit, for example with a force strobe, while the pin is still an input, and enable the output afterwards.

The block has no buffering on the action field. A new value changes the pin source at once and selects the action taken at the very next clock edge.

Top module: `cmp_out_unit`

## Requirements
- R1: An active-low asynchronous reset clears the state bit to 0.
- R2: In the non-PWM modes (waveMode 00 normal, 01 clear-on-match), a match applies the action field: 01 toggles the state bit, 10 clears it, 11 sets it. The new value is visible after the clock edge that samples the match.
- R3: An action field of 00 leaves the state bit unchanged on any event, in all four waveform modes, and the pin shows portData.
- R4: When modeField is not 00, pinOut equals the state bit. When modeField is 00, pinOut equals portData. This holds in every waveform mode, and a change of modeField alters pinOut combinationally.
- R5: pinOe always equals portDir, whatever the action field and waveform mode.
- R6: In the non-PWM modes a force strobe applies the same action as a match. A match and a force in the same cycle apply the action only once, so a toggle flips the bit exactly once.
- R7: In the PWM modes (waveMode 10 fast, 11 phase-correct) a force strobe has no effect on the state bit.
- R8: In fast PWM, field 10 clears the bit on a match and sets it on a bottom pulse, and field 11 does the reverse. If a match and a bottom pulse come together, the match action wins.
- R9: In both PWM modes, field 01 is reserved and performs no action.
- R10: In phase-correct PWM, field 10 clears the bit on a match and field 11 sets it on a match. Bottom pulses are ignored.
- R11: A bottom pulse has no effect in the non-PWM modes. The state bit keeps its value when waveMode changes.
- R12: A change of modeField selects the action applied at the next clock edge, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| matchPulse | input | 1 | One-cycle compare-match event from the counter |
| bottomPulse | input | 1 | One-cycle counter-bottom event |
| forceStrobe | input | 1 | One-cycle software force-compare strobe |
| modeField | input | 2 | Compare action and pin-override field |
| waveMode | input | 2 | 00 normal, 01 clear-on-match, 10 fast PWM, 11 phase-correct PWM |
| portData | input | 1 | Port data bit for the pin |
| portDir | input | 1 | Port direction bit (1 = output) |
| pinOut | output | 1 | Value presented to the pin |
| pinOe | output | 1 | Pin output enable |

## Verification
A wrong state bit is visible only through pinOut, and only while the action field is nonzero. The bench therefore reads the bit by briefly setting the field to 11 between clock edges, with no event pending. A wrong action decode shows on the edge right after the event, one cycle after the stimulus. A wrong pin-source decision shows at once, without any clock edge, when modeField or portData changes.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;
  localparam int MODE_W = 2;
  localparam int WAVE_W = 2;

  typedef enum logic [WAVE_W-1:0] {
    WAVE_NORMAL = 2'b00,
    WAVE_CTC    = 2'b01,
    WAVE_FAST   = 2'b10,
    WAVE_PHASE  = 2'b11
  } waveMode_e;

  localparam logic [MODE_W-1:0] ACT_NONE = 2'b00;
  localparam logic [MODE_W-1:0] ACT_ALT  = 2'b01;
  localparam logic [MODE_W-1:0] ACT_LOW  = 2'b10;
  localparam logic [MODE_W-1:0] ACT_HIGH = 2'b11;

  // Strobes from the control module to the datapath (at most one active)
  typedef struct packed {
    logic doSet;
    logic doClr;
    logic doTgl;
  } stateCmd_t;
endpackage

// File: rtl/cmp_out_ctrl.sv
module cmp_out_ctrl
  import cmp_out_pkg::*;
(
  input  logic              matchPulse,
  input  logic              bottomPulse,
  input  logic              forceStrobe,
  input  logic [MODE_W-1:0] modeField,
  input  logic [WAVE_W-1:0] waveMode,
  output stateCmd_t         cmd,
  output logic              overrideEn
);
  waveMode_e wave;
  logic      isPwm;
  logic      anyEvt;

  assign wave       = waveMode_e'(waveMode);
  assign isPwm      = waveMode[WAVE_W-1];
  // Match and force merge into a single event so that the action is applied once
  assign anyEvt     = matchPulse | (forceStrobe & ~isPwm);
  assign overrideEn = |modeField;

  always_comb begin
    cmd = '0;
    unique case (wave)
      WAVE_NORMAL, WAVE_CTC: begin
        if (anyEvt) begin
          unique case (modeField)
            ACT_ALT:  cmd.doTgl = 1'b1;
            ACT_LOW:  cmd.doClr = 1'b1;
            ACT_HIGH: cmd.doSet = 1'b1;
            default:  cmd = '0;
          endcase
        end
      end
      WAVE_FAST: begin
        if (matchPulse) begin
          if (modeField == ACT_LOW)  cmd.doClr = 1'b1;
          if (modeField == ACT_HIGH) cmd.doSet = 1'b1;
        end else if (bottomPulse) begin
          if (modeField == ACT_LOW)  cmd.doSet = 1'b1;
          if (modeField == ACT_HIGH) cmd.doClr = 1'b1;
        end
      end
      WAVE_PHASE: begin
        if (matchPulse) begin
          if (modeField == ACT_LOW)  cmd.doClr = 1'b1;
          if (modeField == ACT_HIGH) cmd.doSet = 1'b1;
        end
      end
      default: cmd = '0;
    endcase
  end
endmodule

// File: rtl/cmp_out_datapath.sv
module cmp_out_datapath
  import cmp_out_pkg::*;
#(
  parameter logic RESET_STATE = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  stateCmd_t cmd,
  input  logic      overrideEn,
  input  logic      portData,
  input  logic      portDir,
  output logic      pinOut,
  output logic      pinOe,
  output logic      ocState
);
  logic stateNext;

  always_comb begin
    stateNext = ocState;
    if (cmd.doSet)      stateNext = 1'b1;
    else if (cmd.doClr) stateNext = 1'b0;
    else if (cmd.doTgl) stateNext = ~ocState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ocState <= RESET_STATE;
    else       ocState <= stateNext;
  end

  assign pinOut = overrideEn ? ocState : portData;
  assign pinOe  = portDir;
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
  import cmp_out_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       matchPulse,
  input  logic       bottomPulse,
  input  logic       forceStrobe,
  input  logic [1:0] modeField,
  input  logic [1:0] waveMode,
  input  logic       portData,
  input  logic       portDir,
  output logic       pinOut,
  output logic       pinOe
);
  stateCmd_t cmd;
  logic      overrideEn;
  logic      ocState;

  cmp_out_ctrl i_ctrl (
    .matchPulse (matchPulse),
    .bottomPulse(bottomPulse),
    .forceStrobe(forceStrobe),
    .modeField  (modeField),
    .waveMode   (waveMode),
    .cmd        (cmd),
    .overrideEn (overrideEn)
  );

  cmp_out_datapath #(.RESET_STATE(1'b0)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .overrideEn(overrideEn),
    .portData  (portData),
    .portDir   (portDir),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .ocState   (ocState)
  );
endmodule

// File: rtl/cmp_out_checker.sv
module cmp_out_checker (
  input logic       clk,
  input logic       rstN,
  input logic       matchPulse,
  input logic       bottomPulse,
  input logic       forceStrobe,
  input logic [1:0] modeField,
  input logic [1:0] waveMode,
  input logic       pinOut,
  input logic       pinOe,
  input logic       portDir,
  input logic       ocState
);
  AST_RESET_CLEARS: assert property (@(posedge clk) $rose(rstN) |-> !ocState); // R1

  AST_NONPWM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (!waveMode[1] && modeField == 2'b10 && (matchPulse || forceStrobe)) |=> !ocState); // R2

  AST_NONPWM_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!waveMode[1] && modeField == 2'b11 && (matchPulse || forceStrobe)) |=> ocState); // R2

  AST_TOGGLE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (!waveMode[1] && modeField == 2'b01 && (matchPulse || forceStrobe)) |=> ocState != $past(ocState)); // R6

  AST_FIELD_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (modeField == 2'b00) |=> $stable(ocState)); // R3

  AST_PIN_FROM_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (modeField != 2'b00) |-> pinOut == ocState); // R4

  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    pinOe == portDir); // R5

  AST_PWM_FORCE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (waveMode[1] && forceStrobe && !matchPulse && !bottomPulse) |=> $stable(ocState)); // R7

  AST_FAST_BOTTOM_SET: assert property (@(posedge clk) disable iff (!rstN)
    (waveMode == 2'b10 && modeField == 2'b10 && bottomPulse && !matchPulse) |=> ocState); // R8

  AST_PWM_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (waveMode[1] && modeField == 2'b01) |=> $stable(ocState)); // R9

  AST_NO_EVENT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!matchPulse && !forceStrobe && !bottomPulse) |=> $stable(ocState)); // R11
endmodule

bind cmp_out_unit cmp_out_checker i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .matchPulse (matchPulse),
  .bottomPulse(bottomPulse),
  .forceStrobe(forceStrobe),
  .modeField  (modeField),
  .waveMode   (waveMode),
  .pinOut     (pinOut),
  .pinOe      (pinOe),
  .portDir    (portDir),
  .ocState    (ocState)
);

// File: tb/test_cmp_out_unit.sv
`timescale 1ns/1ps
module test_cmp_out_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       matchPulse = 1'b0;
  logic       bottomPulse = 1'b0;
  logic       forceStrobe = 1'b0;
  logic [1:0] modeField = 2'b00;
  logic [1:0] waveMode = 2'b00;
  logic       portData = 1'b0;
  logic       portDir = 1'b0;
  logic       pinOut;
  logic       pinOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_out_unit i_cmp_out_unit (
    .clk(clk), .rstN(rstN), .matchPulse(matchPulse), .bottomPulse(bottomPulse),
    .forceStrobe(forceStrobe), .modeField(modeField), .waveMode(waveMode),
    .portData(portData), .portDir(portDir), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input logic actual, input logic expected, input string tag);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, actual, expected);
    end
  endtask

  // Read the state bit through the pin between clock edges, no event pending
  task automatic readState(output logic val);
    logic [1:0] saved;
    saved = modeField;
    #1 modeField = 2'b11;
    #1 val = pinOut;
    modeField = saved;
    #1;
  endtask

  // Drive events for exactly one rising edge; returns just after the next falling edge
  task automatic pulse(input logic m, input logic f, input logic b);
    @(negedge clk);
    matchPulse = m; forceStrobe = f; bottomPulse = b;
    @(negedge clk);
    matchPulse = 0; forceStrobe = 0; bottomPulse = 0;
  endtask

  // Set the state bit to a known value in normal mode
  task automatic preload(input logic v);
    waveMode = 2'b00;
    modeField = v ? 2'b11 : 2'b10;
    pulse(0, 1, 0);
  endtask

  task automatic testReset();
    logic s;
    @(negedge clk);
    readState(s);
    check(s, 1'b0, "R1 reset state");
  endtask

  task automatic testNonPwm();
    logic s;
    waveMode = 2'b00; modeField = 2'b11; pulse(1, 0, 0);
    readState(s); check(s, 1'b1, "R2 set on match");
    modeField = 2'b01; pulse(1, 0, 0);
    readState(s); check(s, 1'b0, "R2 toggle on match");
    waveMode = 2'b01; modeField = 2'b01; pulse(1, 0, 0);
    readState(s); check(s, 1'b1, "R2 toggle ctc");
    modeField = 2'b10; pulse(1, 0, 0);
    readState(s); check(s, 1'b0, "R2 clear ctc");
    pulse(0, 0, 1); modeField = 2'b11; pulse(0, 0, 1);
    readState(s); check(s, 1'b0, "R11 bottom ignored non-pwm");
  endtask

  task automatic testFieldZero();
    logic s;
    for (int w = 0; w < 4; w++) begin
      preload(1'b1);
      waveMode = 2'(w); modeField = 2'b00;
      pulse(1, 1, 1);
      readState(s); check(s, 1'b1, "R3 field zero no action");
    end
  endtask

  task automatic testPin();
    @(negedge clk);
    preload(1'b1);
    portDir = 1'b0; portData = 1'b0; modeField = 2'b00;
    #1 check(pinOut, 1'b0, "R4 port data when field zero");
    check(pinOe, 1'b0, "R5 oe low");
    modeField = 2'b10;
    #1 check(pinOut, 1'b1, "R4 state overrides pin");
    check(pinOe, 1'b0, "R5 oe still from dir");
    waveMode = 2'b10; modeField = 2'b01; portDir = 1'b1;
    #1 check(pinOut, 1'b1, "R4 override in pwm reserved field");
    check(pinOe, 1'b1, "R5 oe high");
    modeField = 2'b00; portData = 1'b0;
    #1 check(pinOut, 1'b0, "R4 release to port data");
    portDir = 1'b0;
  endtask

  task automatic testForce();
    logic s;
    preload(1'b0);
    modeField = 2'b11; pulse(0, 1, 0);
    readState(s); check(s, 1'b1, "R6 force sets");
    modeField = 2'b01; pulse(1, 1, 0);
    readState(s); check(s, 1'b0, "R6 match+force toggles once");
    pulse(0, 1, 0);
    readState(s); check(s, 1'b1, "R6 force toggles");
  endtask

  task automatic testPwmForce();
    logic s;
    preload(1'b0);
    waveMode = 2'b10; modeField = 2'b11; pulse(0, 1, 0);
    readState(s); check(s, 1'b0, "R7 force ignored fast");
    waveMode = 2'b11; pulse(0, 1, 0);
    readState(s); check(s, 1'b0, "R7 force ignored phase");
  endtask

  task automatic testFast();
    logic s;
    preload(1'b1);
    waveMode = 2'b10; modeField = 2'b10; pulse(1, 0, 0);
    readState(s); check(s, 1'b0, "R8 fast 10 clear on match");
    pulse(0, 0, 1);
    readState(s); check(s, 1'b1, "R8 fast 10 set at bottom");
    modeField = 2'b11; pulse(0, 0, 1);
    readState(s); check(s, 1'b0, "R8 fast 11 clear at bottom");
    pulse(1, 0, 0);
    readState(s); check(s, 1'b1, "R8 fast 11 set on match");
    modeField = 2'b10; pulse(1, 0, 1);
    readState(s); check(s, 1'b0, "R8 match wins over bottom");
    modeField = 2'b01; pulse(1, 0, 0); pulse(0, 0, 1);
    readState(s); check(s, 1'b0, "R9 fast reserved");
  endtask

  task automatic testPhase();
    logic s;
    preload(1'b0);
    waveMode = 2'b11; modeField = 2'b11; pulse(1, 0, 0);
    readState(s); check(s, 1'b1, "R10 phase set on match");
    modeField = 2'b10; pulse(0, 0, 1);
    readState(s); check(s, 1'b1, "R10 phase bottom ignored");
    pulse(1, 0, 0);
    readState(s); check(s, 1'b0, "R10 phase clear on match");
    modeField = 2'b01; pulse(1, 0, 0);
    readState(s); check(s, 1'b0, "R9 phase reserved");
  endtask

  task automatic testRetainAndImmediate();
    logic s;
    preload(1'b1);
    modeField = 2'b00;
    for (int w = 3; w >= 0; w--) begin
      @(negedge clk); waveMode = 2'(w);
      @(negedge clk);
    end
    readState(s); check(s, 1'b1, "R11 kept across wave modes");
    // Field written in the same low phase as the match is used at that edge
    @(negedge clk);
    modeField = 2'b10; matchPulse = 1'b1;
    @(negedge clk);
    matchPulse = 1'b0;
    readState(s); check(s, 1'b0, "R12 new field used at next edge");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testNonPwm();
    testFieldZero();
    testPin();
    testForce();
    testPwmForce();
    testFast();
    testPhase();
    testRetainAndImmediate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule